// File: doc/BRIEF.md
# Packed 2-bit Index Vector Lookup

This block fills a 128-bit result vector by table lookup. A second 128-bit operand holds a row of packed 2-bit indices. A segment number picks which slice of that row is used. Each index names one of the four lowest lanes of a 128-bit table operand, and the chosen table lane is copied into the matching result lane. Lanes are either 8 bits wide (16 result lanes) or 16 bits wide (8 result lanes).

The caller presents the operands together with three raw opcode control fields: a 2-bit size control, a 2-bit segment field and a 1-bit op field. The block decodes these fields itself. Legal combinations produce a registered result with a valid flag one clock later. Illegal combinations raise an undefined-operation flag in that same cycle and produce no result. The latency is the same for every data value.

Top module: `lut2_vec_lookup`

## Requirements
- R1: A synchronous, active-high reset drives outValid and outUndef low at the next clock edge and holds them low while reset stays high.
- R2: Byte mode is selected by sizeCtl = 2'b10 with opBit = 1. The segment number s equals segField (0 to 3). Result byte e (e = 0..15) equals table byte k, which sits at tableVec[8k+7:8k]. Here k = indexVec[2(16s+e)+1 : 2(16s+e)].
- R3: Halfword mode is selected by sizeCtl = 2'b11. The segment number s equals {segField, opBit} (0 to 7), with segField as the upper bits. Result halfword e (e = 0..7) equals tableVec[16k+15:16k], where k = indexVec[2(8s+e)+1 : 2(8s+e)].
- R4: Table bits above lane 3 do not affect the result. In byte mode these are tableVec[127:32]; in halfword mode they are tableVec[127:64].
- R5: sizeCtl = 2'b10 with opBit = 0 is undefined. One cycle later outUndef = 1 and outValid = 0, and resultVec keeps its previous value.
- R6: sizeCtl = 2'b00 or 2'b01 is undefined for every segField and opBit value. The response is the same as in R5.
- R7: outValid or outUndef is high exactly one clock after each cycle in which inValid is high. The two flags are never high together, and this latency does not depend on any operand value.
- R8: In a cycle after which inValid was low, both flags are low and resultVec keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operands and control fields are presented this cycle |
| sizeCtl | input | 2 | Lane size control: 10 byte, 11 halfword, others undefined |
| segField | input | 2 | Segment field (segment in byte mode, upper segment bits in halfword mode) |
| opBit | input | 1 | Op bit: must be 1 in byte mode, low segment bit in halfword mode |
| tableVec | input | 128 | Table operand |
| indexVec | input | 128 | Packed 2-bit index operand |
| outValid | output | 1 | resultVec holds a new lookup result |
| outUndef | output | 1 | The previous request had an undefined control combination |
| resultVec | output | 128 | Registered lookup result |

## Verification
A wrong segment offset or a misread opBit in the decode shows up as shifted or swapped result lanes. This appears in the first result after the faulty request, since every request is checked lane by lane one clock after it is issued. A wrong mode decode flips outValid and outUndef in that same cycle. A result register that loads when it should not shows up as a changed resultVec after an idle or undefined request, and this is observed one cycle later.

// File: rtl/lut2_pkg.sv
package lut2_pkg;
  localparam int SEG_W = 3;

  typedef struct packed {
    logic             load;
    logic             undef;
    logic             halfMode;
    logic [SEG_W-1:0] seg;
  } lut2Strobe_t;
endpackage

// File: rtl/lut2_ctrl.sv
module lut2_ctrl
  import lut2_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [1:0]  sizeCtl,
  input  logic [1:0]  segField,
  input  logic        opBit,
  output lut2Strobe_t strb
);
  logic byteOk;
  logic halfOk;

  always_comb begin
    byteOk        = (sizeCtl == 2'b10) && opBit;
    halfOk        = (sizeCtl == 2'b11);
    strb.load     = inValid && (byteOk || halfOk);
    strb.undef    = inValid && !(byteOk || halfOk);
    strb.halfMode = halfOk;
    strb.seg      = halfOk ? {segField, opBit} : {1'b0, segField};
  end

  // R6: a low size-control upper bit can never start a lookup
  a_r6_low_size_undef: assert property (@(posedge clk) disable iff (rst)
    (inValid && !sizeCtl[1]) |-> (strb.undef && !strb.load));

  // R5: byte size with op bit clear is rejected
  a_r5_byte_op0_undef: assert property (@(posedge clk) disable iff (rst)
    (inValid && sizeCtl == 2'b10 && !opBit) |-> strb.undef);

  // R7: at most one of the two strobes per request
  a_r7_strobe_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.load, strb.undef}));
endmodule

// File: rtl/lut2_dpath.sv
module lut2_dpath
  import lut2_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  lut2Strobe_t      strb,
  input  logic [VEC_W-1:0] tableVec,
  input  logic [VEC_W-1:0] indexVec,
  output logic             outValid,
  output logic             outUndef,
  output logic [VEC_W-1:0] resultVec
);
  localparam int IDX_W     = 2;
  localparam int NUM_B     = VEC_W / 8;
  localparam int NUM_H     = VEC_W / 16;
  localparam int BYTE_SPAN = NUM_B * IDX_W;
  localparam int HALF_SPAN = NUM_H * IDX_W;

  logic [VEC_W-1:0] byteIdx;
  logic [VEC_W-1:0] halfIdx;
  logic [VEC_W-1:0] byteRes;
  logic [VEC_W-1:0] halfRes;
  logic [VEC_W-1:0] nextRes;

  always_comb begin
    byteIdx = indexVec >> (int'(strb.seg) * BYTE_SPAN);
    halfIdx = indexVec >> (int'(strb.seg) * HALF_SPAN);
  end

  for (genvar b = 0; b < NUM_B; b++) begin : g_byteLane
    logic [IDX_W-1:0] selB;
    always_comb begin
      selB = byteIdx[IDX_W*b +: IDX_W];
      byteRes[8*b +: 8] = tableVec[{selB, 3'b000} +: 8];
    end
  end

  for (genvar h = 0; h < NUM_H; h++) begin : g_halfLane
    logic [IDX_W-1:0] selH;
    always_comb begin
      selH = halfIdx[IDX_W*h +: IDX_W];
      halfRes[16*h +: 16] = tableVec[{selH, 4'b0000} +: 16];
    end
  end

  always_comb nextRes = strb.halfMode ? halfRes : byteRes;

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      outUndef  <= 1'b0;
      resultVec <= '0;
    end else begin
      outValid <= strb.load;
      outUndef <= strb.undef;
      if (strb.load) resultVec <= nextRes;
    end
  end

  // R7: accepted request reports valid one clock later
  a_r7_valid_latency: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> (outValid && !outUndef));

  // R5: rejected request reports undefined one clock later
  a_r5_undef_latency: assert property (@(posedge clk) disable iff (rst)
    strb.undef |=> (outUndef && !outValid));

  // R8: result register holds unless a lookup was accepted
  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> $stable(resultVec));

  // R7: flags are exclusive
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(outValid && outUndef));
endmodule

// File: rtl/lut2_vec_lookup.sv
module lut2_vec_lookup
  import lut2_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [1:0]       sizeCtl,
  input  logic [1:0]       segField,
  input  logic             opBit,
  input  logic [VEC_W-1:0] tableVec,
  input  logic [VEC_W-1:0] indexVec,
  output logic             outValid,
  output logic             outUndef,
  output logic [VEC_W-1:0] resultVec
);
  lut2Strobe_t strb;

  lut2_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .sizeCtl  (sizeCtl),
    .segField (segField),
    .opBit    (opBit),
    .strb     (strb)
  );

  lut2_dpath #(.VEC_W(VEC_W)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .tableVec  (tableVec),
    .indexVec  (indexVec),
    .outValid  (outValid),
    .outUndef  (outUndef),
    .resultVec (resultVec)
  );
endmodule

// File: tb/lut2_vec_lookup_bench.sv
module lut2_vec_lookup_bench;
  localparam int VEC_W = 128;
  localparam time HALF_PER = 10ns;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             inValid = 1'b0;
  logic [1:0]       sizeCtl = 2'b00;
  logic [1:0]       segField = 2'b00;
  logic             opBit = 1'b0;
  logic [VEC_W-1:0] tableVec = '0;
  logic [VEC_W-1:0] indexVec = '0;
  logic             outValid;
  logic             outUndef;
  logic [VEC_W-1:0] resultVec;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [63:0] lfsr = 64'h1234_5678_9abc_def1;

  always #HALF_PER clk = ~clk;

  lut2_vec_lookup #(.VEC_W(VEC_W)) u_lut2_vec_lookup (
    .clk(clk), .rst(rst), .inValid(inValid), .sizeCtl(sizeCtl),
    .segField(segField), .opBit(opBit), .tableVec(tableVec),
    .indexVec(indexVec), .outValid(outValid), .outUndef(outUndef),
    .resultVec(resultVec)
  );

  function automatic logic [63:0] stepLfsr(logic [63:0] v);
    return {v[62:0], v[63] ^ v[62] ^ v[60] ^ v[59]};
  endfunction

  task automatic nextRand(output logic [VEC_W-1:0] r);
    for (int i = 0; i < 2; i++) begin
      for (int j = 0; j < 64; j++) lfsr = stepLfsr(lfsr);
      r[64*i +: 64] = lfsr;
    end
  endtask

  function automatic logic [VEC_W-1:0] model(bit half, int seg,
      logic [VEC_W-1:0] tbl, logic [VEC_W-1:0] idx);
    logic [VEC_W-1:0] r;
    int lw;
    int lanes;
    r = '0;
    lw = half ? 16 : 8;
    lanes = VEC_W / lw;
    for (int e = 0; e < lanes; e++) begin
      int k;
      k = int'(idx[2*(lanes*seg + e) +: 2]);
      for (int bt = 0; bt < lw; bt++) r[e*lw + bt] = tbl[k*lw + bt];
    end
    return r;
  endfunction

  task automatic checkBit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic checkVec(string req, logic [VEC_W-1:0] act, logic [VEC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one request at a negedge, sample at the following negedge
  task automatic issue(logic [1:0] sz, logic [1:0] sf, logic ob,
      logic [VEC_W-1:0] tbl, logic [VEC_W-1:0] idx);
    @(negedge clk);
    inValid = 1'b1; sizeCtl = sz; segField = sf; opBit = ob;
    tableVec = tbl; indexVec = idx;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #(HALF_PER * 2 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [VEC_W-1:0] tbl;
    logic [VEC_W-1:0] idx;
    logic [VEC_W-1:0] exp;
    logic [VEC_W-1:0] held;

    repeat (3) @(negedge clk);
    // R1: reset state
    checkBit("R1 outValid in reset", outValid, 1'b0);
    checkBit("R1 outUndef in reset", outUndef, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkBit("R1 outValid after reset", outValid, 1'b0);

    // R2: byte mode, all segments, several data patterns
    for (int p = 0; p < 6; p++) begin
      for (int s = 0; s < 4; s++) begin
        nextRand(tbl); nextRand(idx);
        if (p == 0) idx = '0;
        if (p == 1) idx = '1;
        if (p == 2) idx = {VEC_W/8{8'he4}};
        exp = model(1'b0, s, tbl, idx);
        issue(2'b10, 2'(s), 1'b1, tbl, idx);
        checkBit("R2 byte outValid", outValid, 1'b1);
        checkBit("R7 byte outUndef low", outUndef, 1'b0);
        checkVec("R2 byte result", resultVec, exp);
      end
    end

    // R3: halfword mode, all eight segments
    for (int p = 0; p < 6; p++) begin
      for (int s = 0; s < 8; s++) begin
        nextRand(tbl); nextRand(idx);
        if (p == 0) idx = '0;
        if (p == 1) idx = '1;
        if (p == 2) idx = {VEC_W/8{8'h1b}};
        exp = model(1'b1, s, tbl, idx);
        issue(2'b11, 2'(s >> 1), 1'(s & 1), tbl, idx);
        checkBit("R3 half outValid", outValid, 1'b1);
        checkBit("R7 half outUndef low", outUndef, 1'b0);
        checkVec("R3 half result", resultVec, exp);
      end
    end

    // R4: upper table lanes have no effect
    for (int s = 0; s < 4; s++) begin
      nextRand(tbl); nextRand(idx);
      exp = model(1'b0, s, tbl, idx);
      tbl[VEC_W-1:32] = ~tbl[VEC_W-1:32];
      issue(2'b10, 2'(s), 1'b1, tbl, idx);
      checkVec("R4 byte upper table ignored", resultVec, exp);
      nextRand(tbl);
      exp = model(1'b1, 2*s+1, tbl, idx);
      tbl[VEC_W-1:64] = ~tbl[VEC_W-1:64];
      issue(2'b11, 2'(s), 1'b1, tbl, idx);
      checkVec("R4 half upper table ignored", resultVec, exp);
    end

    // R5: byte size with op bit 0
    held = resultVec;
    for (int s = 0; s < 4; s++) begin
      nextRand(tbl); nextRand(idx);
      issue(2'b10, 2'(s), 1'b0, tbl, idx);
      checkBit("R5 outUndef", outUndef, 1'b1);
      checkBit("R5 outValid low", outValid, 1'b0);
      checkVec("R5 result held", resultVec, held);
    end

    // R6: size 00 and 01 for every segment/op value
    for (int sz = 0; sz < 2; sz++) begin
      for (int c = 0; c < 8; c++) begin
        nextRand(tbl); nextRand(idx);
        issue(2'(sz), 2'(c >> 1), 1'(c & 1), tbl, idx);
        checkBit("R6 outUndef", outUndef, 1'b1);
        checkBit("R6 outValid low", outValid, 1'b0);
        checkVec("R6 result held", resultVec, held);
      end
    end

    // R8: idle cycles with changing operands
    nextRand(tbl); nextRand(idx);
    issue(2'b11, 2'b01, 1'b0, tbl, idx);
    held = resultVec;
    checkVec("R3 before idle", held, model(1'b1, 2, tbl, idx));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      nextRand(tableVec); nextRand(indexVec);
      sizeCtl = 2'b10; opBit = 1'b1;
      @(negedge clk);
      checkBit("R8 idle outValid", outValid, 1'b0);
      checkBit("R8 idle outUndef", outUndef, 1'b0);
      checkVec("R8 idle result held", resultVec, held);
    end

    // R7: back-to-back requests, one flag per clock
    @(negedge clk);
    nextRand(tbl); nextRand(idx);
    inValid = 1'b1; sizeCtl = 2'b10; segField = 2'b11; opBit = 1'b1;
    tableVec = tbl; indexVec = idx;
    exp = model(1'b0, 3, tbl, idx);
    @(negedge clk);
    checkBit("R7 b2b first valid", outValid, 1'b1);
    checkVec("R7 b2b first result", resultVec, exp);
    sizeCtl = 2'b01;
    @(negedge clk);
    checkBit("R7 b2b second undef", outUndef, 1'b1);
    checkBit("R7 b2b second valid low", outValid, 1'b0);
    sizeCtl = 2'b11; segField = 2'b00; opBit = 1'b0;
    exp = model(1'b1, 0, tbl, idx);
    @(negedge clk);
    inValid = 1'b0;
    checkBit("R7 b2b third valid", outValid, 1'b1);
    checkVec("R7 b2b third result", resultVec, exp);

    // R1: reset in mid-stream clears flags
    @(negedge clk);
    inValid = 1'b1; rst = 1'b1;
    @(negedge clk);
    checkBit("R1 reset beats request valid", outValid, 1'b0);
    checkBit("R1 reset beats request undef", outUndef, 1'b0);
    inValid = 1'b0; rst = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule